// File: doc/BRIEF.md
# Crosspoint Matrix Serial Configuration Loader

This block programs an external analog crosspoint switch matrix through its serial port. It accepts a configuration word with one bit per crosspoint: ROWS x COLS bits, which is 256 for the default 16x16 matrix. It accepts the word through a valid/ready handshake. It then divides the system clock down to a serial clock and shifts the word out most significant bit first. After exactly one frame it stops the serial clock. It waits a setup interval and then drives a single active-low load strobe, which makes the device copy its shift register into the switch latches.

The device's serial output returns whatever was clocked into it one frame earlier. When a frame is requested with the verify bit set, the block samples that returned stream at every rising serial-clock edge. It compares each sample with the matching bit of the previously sent frame and raises a sticky mismatch flag on the first difference.

Back-pressure rules: `cfg_ready` is high only while the block is idle. A word is taken on a clock edge where `cfg_valid` and `cfg_ready` are both high. While a frame is in flight, `cfg_ready` is low and the word and verify bit are neither taken nor sampled. A source that keeps `cfg_valid` high is served as soon as the current frame ends.

Top module: `xbar_cfg_loader`

## Requirements
- R1: A word and its verify bit are captured only on an edge where `cfg_valid` and `cfg_ready` are both high. `cfg_ready` is high exactly when `busy` is low. An offer made while busy changes neither the frame in flight nor what the device latches.
- R2: Each bit lasts DIV system clocks. `xp_sclk` is low for the first DIV/2 clocks of the bit and high for the last DIV/2. Exactly ROWS*COLS rising edges occur per frame, and `xp_sclk` is held low at all other times.
- R3: Bit ROWS*COLS-1 is sent first. `xp_sdata` takes the next bit in the same cycle that `xp_sclk` falls and holds it while `xp_sclk` is high. It is 0 outside the shifting phase. After the frame, the device latches the exact word that was captured.
- R4: `xp_load_n` stays high for SETUP_PERIODS*DIV system clocks after the last falling serial-clock edge, and then falls.
- R5: `xp_load_n` is low for exactly LATCH_PERIODS*DIV system clocks, once per frame, and is high otherwise. `xp_sclk` is low throughout the strobe.
- R6: `busy` is high from the cycle after acceptance until the cycle in which `xp_load_n` returns high. `done` is high for that one cycle only.
- R7: In a verify frame, the synchronized `xp_sout` sampled at rising edge k is compared with bit ROWS*COLS-1-k of the previous frame. `mismatch` is set on a difference, visible DIV/2 cycles after the first differing bit's frame start plus k*DIV. It stays set until reset. Frames without verify never set it.
- R8: While `rst_n` is low at a clock edge, the block returns to idle. After that edge, `xp_sclk` is low, `xp_load_n` is high, `busy`, `done` and `mismatch` are low, and the bit counter is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Block idle, word will be taken |
| cfg_word | input | ROWS*COLS | One bit per crosspoint, MSB sent first |
| cfg_verify | input | 1 | Compare the returned echo against the previous frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the load strobe ends |
| mismatch | output | 1 | Sticky echo compare failure |
| xp_sclk | output | 1 | Serial clock to the device |
| xp_sdata | output | 1 | Serial data to the device |
| xp_load_n | output | 1 | Active-low latch strobe to the device |
| xp_sout | input | 1 | Serial echo from the device |

## Verification
The bench builds the block as a 4x4 matrix (16-bit frames) with DIV=6, SETUP_PERIODS=2, LATCH_PERIODS=3 and SYNC_STAGES=2. One frame therefore takes 126 cycles, so a dozen frames fit easily. The odd half-period of three clocks and the unequal setup and strobe lengths expose any mix-up between the phase counter and the period counter. Two synchronizer stages against a six-clock bit bring the echo sampling window close to its limit. A device model echoes and latches the stream. Its echo can be inverted for one frame, which drives the mismatch path in both verify and plain frames.

// File: rtl/xcl_pkg.sv
package xcl_pkg;
  typedef enum logic [1:0] {
    XS_IDLE,
    XS_SHIFT,
    XS_SETUP,
    XS_LATCH
  } xcl_state_e;
endpackage

// File: rtl/xcl_tick.sv
// Free-running bit-phase counter; marks the serial rising and falling edges.
module xcl_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) phase <= '0;
    else if (phase == PW'(DIV - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign rise_tick = run && (phase == PW'(HALF - 1));
  assign fall_tick = run && (phase == PW'(DIV - 1));
endmodule

// File: rtl/xcl_sync.sv
// Synchronizer for the device echo; zero stages gives a plain wire.
module xcl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  if (STAGES == 0) begin : g_wire
    assign q = d;
  end else begin : g_chain
    logic [STAGES-1:0] q_r;
    logic [STAGES:0]   taps;
    assign taps = {q_r, d};
    always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else q_r <= taps[STAGES-1:0];
    end
    assign q = q_r[STAGES-1];
  end
endmodule

// File: rtl/xcl_frame.sv
// Current and previous frame stores; both rotate so they return intact.
module xcl_frame #(
  parameter int BITS = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] word,
  input  logic            rotate,
  output logic            cur_msb,
  output logic            prev_msb
);
  logic [BITS-1:0] cur_q;
  logic [BITS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (load) begin
      prev_q <= cur_q;
      cur_q  <= word;
    end else if (rotate) begin
      cur_q  <= {cur_q[BITS-2:0], cur_q[BITS-1]};
      prev_q <= {prev_q[BITS-2:0], prev_q[BITS-1]};
    end
  end

  assign cur_msb  = cur_q[BITS-1];
  assign prev_msb = prev_q[BITS-1];
endmodule

// File: rtl/xbar_cfg_loader.sv
module xbar_cfg_loader #(
  parameter int ROWS          = 16,
  parameter int COLS          = 16,
  parameter int DIV           = 4,
  parameter int SETUP_PERIODS = 1,
  parameter int LATCH_PERIODS = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic [ROWS*COLS-1:0] cfg_word,
  input  logic                 cfg_verify,
  output logic                 busy,
  output logic                 done,
  output logic                 mismatch,
  output logic                 xp_sclk,
  output logic                 xp_sdata,
  output logic                 xp_load_n,
  input  logic                 xp_sout
);
  import xcl_pkg::*;

  localparam int BITS = ROWS * COLS;
  localparam int PMAX = (SETUP_PERIODS > LATCH_PERIODS) ? SETUP_PERIODS : LATCH_PERIODS;
  localparam int CMAX = (BITS > PMAX) ? BITS : PMAX;
  localparam int CW   = $clog2(CMAX + 1);

  xcl_state_e    state;
  logic [CW-1:0] cnt;
  logic          sclk_q, load_n_q, done_q, mis_q, verify_q;
  logic          rise_tick, fall_tick, echo_s, cur_msb, prev_msb;
  logic          accept, rotate, run;

  assign run    = (state != XS_IDLE);
  assign accept = (state == XS_IDLE) && cfg_valid;
  assign rotate = (state == XS_SHIFT) && fall_tick;

  xcl_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  xcl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(xp_sout), .q(echo_s)
  );

  xcl_frame #(.BITS(BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(accept), .word(cfg_word),
    .rotate(rotate), .cur_msb(cur_msb), .prev_msb(prev_msb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= XS_IDLE;
      cnt      <= '0;
      sclk_q   <= 1'b0;
      load_n_q <= 1'b1;
      done_q   <= 1'b0;
      mis_q    <= 1'b0;
      verify_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        XS_IDLE: begin
          if (cfg_valid) begin
            state    <= XS_SHIFT;
            cnt      <= '0;
            verify_q <= cfg_verify;
          end
        end
        XS_SHIFT: begin
          if (rise_tick) begin
            sclk_q <= 1'b1;
            if (verify_q && (echo_s != prev_msb)) mis_q <= 1'b1;
          end
          if (fall_tick) begin
            sclk_q <= 1'b0;
            if (cnt == CW'(BITS - 1)) begin
              state <= XS_SETUP;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        XS_SETUP: begin
          if (fall_tick) begin
            if (cnt == CW'(SETUP_PERIODS - 1)) begin
              state    <= XS_LATCH;
              cnt      <= '0;
              load_n_q <= 1'b0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        XS_LATCH: begin
          if (fall_tick) begin
            if (cnt == CW'(LATCH_PERIODS - 1)) begin
              state    <= XS_IDLE;
              cnt      <= '0;
              load_n_q <= 1'b1;
              done_q   <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign cfg_ready = (state == XS_IDLE);
  assign busy      = run;
  assign done      = done_q;
  assign mismatch  = mis_q;
  assign xp_sclk   = sclk_q;
  assign xp_sdata  = (state == XS_SHIFT) && cur_msb;
  assign xp_load_n = load_n_q;
endmodule

// File: rtl/xcl_loader_chk.sv
module xcl_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_valid,
  input logic busy,
  input logic done,
  input logic mismatch,
  input logic xp_sclk,
  input logic xp_sdata,
  input logic xp_load_n
);
  logic was_rst = 1'b0;
  always @(posedge clk) was_rst <= !rst_n;

  always @(negedge clk) begin
    if (was_rst) begin
      AST_RESET_IDLE: assert (!xp_sclk && xp_load_n && !busy && !done && !mismatch); // R8
    end
  end

  AST_BUSY_NEEDS_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cfg_valid)); // R1

  AST_SCLK_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xp_sclk); // R2

  AST_SDATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (xp_sclk && $past(xp_sclk)) |-> $stable(xp_sdata)); // R3

  AST_STROBE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !xp_load_n |-> !xp_sclk); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_ON_STROBE_END: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($rose(xp_load_n) && !busy)); // R6

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> mismatch); // R7
endmodule

bind xbar_cfg_loader xcl_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .busy(busy),
  .done(done), .mismatch(mismatch), .xp_sclk(xp_sclk),
  .xp_sdata(xp_sdata), .xp_load_n(xp_load_n)
);

// File: tb/sim_xbar_cfg_loader.sv
`timescale 1ns/1ps
module sim_xbar_cfg_loader;
  localparam int ROWS = 4, COLS = 4, DIV = 6, SP = 2, LP = 3, SY = 2;
  localparam int BITS = ROWS * COLS;
  localparam int HALF = DIV / 2;
  localparam int SHIFT_END = BITS * DIV;
  localparam int SETUP_END = (BITS + SP) * DIV;
  localparam int FRAME_END = (BITS + SP + LP) * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 1'b0;
  logic cfg_verify = 1'b0;
  logic [BITS-1:0] cfg_word = '0;
  logic cfg_ready, busy, done, mismatch, xp_sclk, xp_sdata, xp_load_n, xp_sout;

  always #4 clk = ~clk;

  xbar_cfg_loader #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .SETUP_PERIODS(SP),
                    .LATCH_PERIODS(LP), .SYNC_STAGES(SY)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .cfg_verify(cfg_verify), .busy(busy), .done(done),
    .mismatch(mismatch), .xp_sclk(xp_sclk), .xp_sdata(xp_sdata),
    .xp_load_n(xp_load_n), .xp_sout(xp_sout)
  );

  // Device model: shifts on rising serial clock, latches at end of strobe.
  logic [BITS-1:0] dev = '0;
  logic [BITS-1:0] latched = '0;
  logic flip = 1'b0;
  always @(posedge xp_sclk) dev <= {dev[BITS-2:0], xp_sdata};
  always @(posedge xp_load_n) latched <= dev;
  assign xp_sout = dev[BITS-1] ^ flip;

  int checks = 0;
  int fails = 0;
  bit chk_en = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Reference model, advanced on every clock edge.
  int r = FRAME_END;
  bit m_done = 1'b0, m_mis = 1'b0, m_verify = 1'b0, m_flip = 1'b0;
  logic [BITS-1:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      r = FRAME_END; m_done = 1'b0; m_mis = 1'b0;
    end else begin
      m_done = 1'b0;
      if (r < FRAME_END) begin
        r++;
        if (r == FRAME_END) m_done = 1'b1;
        if (r == HALF && m_verify && m_flip) m_mis = 1'b1;
      end else if (cfg_valid) begin
        r = 0; m_word = cfg_word; m_verify = cfg_verify; m_flip = flip;
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      chk("R6", "busy", busy, r < FRAME_END);
      chk("R1", "cfg_ready", cfg_ready, r >= FRAME_END);
      chk("R2", "xp_sclk", xp_sclk, (r < SHIFT_END) && ((r % DIV) >= HALF));
      chk("R3", "xp_sdata", xp_sdata, (r < SHIFT_END) ? m_word[BITS-1-(r/DIV)] : 1'b0);
      if (r >= SHIFT_END && r < SETUP_END)
        chk("R4", "xp_load_n setup", xp_load_n, 1'b1);
      else
        chk("R5", "xp_load_n", xp_load_n, !(r >= SETUP_END && r < FRAME_END));
      chk("R6", "done", done, m_done);
      chk("R7", "mismatch", mismatch, m_mis);
    end
  end

  task automatic send(input logic [BITS-1:0] w, input bit v);
    cfg_word = w; cfg_verify = v; cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "sclk in reset", xp_sclk, 1'b0);
    chk("R8", "load_n in reset", xp_load_n, 1'b1);
    chk("R8", "busy in reset", busy, 1'b0);
    chk("R8", "mismatch in reset", mismatch, 1'b0);
    rst_n = 1'b1; chk_en = 1'b1;
    @(negedge clk);

    // R3: plain frame reaches the device latch intact
    send(16'hA5C3, 1'b0); wait_done();
    chk("R3", "latched A5C3", latched, 16'hA5C3);

    // R7: clean verify frame raises nothing
    send(16'h3C96, 1'b1); wait_done();
    chk("R7", "clean verify", mismatch, 1'b0);
    chk("R3", "latched 3C96", latched, 16'h3C96);

    // R7: corrupted echo in a verify frame
    flip = 1'b1;
    send(16'h0001, 1'b1); wait_done();
    flip = 1'b0;
    chk("R7", "corrupt verify", mismatch, 1'b1);

    // R1: offer during busy is ignored; R7 flag stays set
    send(16'hF00D, 1'b0);
    cfg_word = 16'h1234; cfg_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1", "ready low while busy", cfg_ready, 1'b0);
    cfg_valid = 1'b0;
    wait_done();
    chk("R1", "latched unaffected", latched, 16'hF00D);
    chk("R7", "sticky", mismatch, 1'b1);

    // R8: reset in the middle of a frame
    send(16'hBEEF, 1'b0);
    repeat (40) @(negedge clk);
    chk_en = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8", "sclk mid reset", xp_sclk, 1'b0);
    chk("R8", "load_n mid reset", xp_load_n, 1'b1);
    chk("R8", "busy mid reset", busy, 1'b0);
    chk("R8", "mismatch cleared", mismatch, 1'b0);
    rst_n = 1'b1; chk_en = 1'b1;
    @(negedge clk);

    // R6: back-to-back frames with valid held
    send(16'hFFFF, 1'b0);
    send(16'h0000, 1'b1);
    wait_done();
    chk("R3", "latched zeros", latched, 16'h0000);
    chk("R7", "verify after back-to-back", mismatch, 1'b0);

    // R7: corrupted echo without verify leaves flag clear
    flip = 1'b1;
    send(16'h8001, 1'b0); wait_done();
    flip = 1'b0;
    chk("R7", "no verify no flag", mismatch, 1'b0);
    send(16'h7FFE, 1'b1); wait_done();
    chk("R7", "verify after plain", mismatch, 1'b0);
    chk("R3", "latched 7FFE", latched, 16'h7FFE);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule